// File: doc/BRIEF.md
# Configurable Microcontroller I/O Port

This block controls eight package pins for a microcontroller. The processor reaches it through a small register window. It can write an output latch and read it back, program a direction mask and a configuration byte, and sample the live pin levels. Each pin's driver is switched on by its direction bit OR an externally supplied output-enable term, so programmable logic elsewhere on the chip can take control of the driver without software.

Beyond plain I/O, the port has three other functions. It can pass through combinational logic outputs. It can present a low address byte that is captured from the multiplexed bus while the address latch enable (ALE) is high. It can also act as an input that supplies extra high address bits, which are either used live or captured on ALE. Each of the four upper pins can be set to open-drain, so that it only ever pulls low.

Top module: `mcu_port`

## Requirements
- R1: After reset, the output latch, the direction mask and the configuration byte all read 0. This places the port in plain I/O with every pin push-pull.
- R2: With reg_sel = 0, rd_data equals pin_in in the same cycle, with no storage in between.
- R3: A clock edge with wr_en = 1 and reg_sel = 1 loads wr_data into the output latch. Reading with reg_sel = 1 returns the latched value, whatever the pin levels are.
- R4: reg_sel = 2 writes and reads the direction mask. reg_sel = 3 writes and reads the configuration byte, where bits [1:0] select the function (0 plain I/O, 1 logic output, 2 address output, 3 address input), bit 2 enables ALE capture in address-input mode, bit 3 always reads 0, and bits [7:4] are open-drain enables for pins 7..4.
- R5: In plain I/O, pin_out equals the output latch and pin_oe[i] = dir[i] | oe_term[i].
- R6: In logic-output mode, pin_out equals logic_out and pin_oe uses the same enable as in R5.
- R7: In address-output mode, every pin is driven with the address latch. The latch follows addr_bus while ale is high and holds its last value after ale falls.
- R8: In address-input mode, no pin is driven. With bit 2 clear, addr_hi equals pin_in. With bit 2 set, addr_hi follows pin_in while ale is high and holds after ale falls. In every other function, addr_hi is 0.
- R9: An upper pin with its open-drain bit set outputs 0 and is enabled only while its enable is on and its source value is 0. The lower four pins stay push-pull.
- R10: A write with reg_sel = 0 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 pins, 1 output latch, 2 direction, 3 configuration |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data |
| ale | input | 1 | Address latch enable |
| addr_bus | input | 8 | Multiplexed bus low address byte |
| oe_term | input | 8 | External per-pin output-enable term |
| logic_out | input | 8 | Combinational logic outputs |
| pin_in | input | 8 | Sampled pin levels |
| pin_out | output | 8 | Value presented to each pad |
| pin_oe | output | 8 | Tri-state enable for each pad |
| addr_hi | output | 8 | High address bits taken from the pins |

## Verification
The assertions assume that wr_en, reg_sel and wr_data are steady around each rising edge. They also assume that ale only changes at edges, so that the hold checks on the address latches see a clean high-to-low transition. The bench changes every input just after a falling edge and samples outputs one nanosecond later, which keeps these assumptions true. The combinational paths, pin_in to rd_data and the pins to addr_hi, are checked within the cycle in which their inputs change.

// File: rtl/mcu_port_pkg.sv
package mcu_port_pkg;
  localparam int PORT_W  = 8;
  localparam int OD_LSB  = PORT_W / 2;
  localparam int CAP_BIT = 2;
  localparam int RSV_BIT = 3;
  localparam logic [PORT_W-1:0] CFG_WMASK = ~(PORT_W'(1) << RSV_BIT);

  typedef enum logic [1:0] {
    FN_GPIO     = 2'd0,
    FN_LOGIC    = 2'd1,
    FN_ADDR_OUT = 2'd2,
    FN_ADDR_IN  = 2'd3
  } port_fn_e;

  typedef enum logic [1:0] {
    SEL_PINS = 2'd0,
    SEL_DOUT = 2'd1,
    SEL_DIR  = 2'd2,
    SEL_CFG  = 2'd3
  } reg_sel_e;

  // value a pin would present before open-drain shaping
  function automatic logic src_bit(port_fn_e fn, logic dout, logic lgc, logic adr);
    case (fn)
      FN_LOGIC:    return lgc;
      FN_ADDR_OUT: return adr;
      FN_ADDR_IN:  return 1'b0;
      default:     return dout;
    endcase
  endfunction

  // driver request before open-drain shaping
  function automatic logic drive_bit(port_fn_e fn, logic dir, logic oet);
    case (fn)
      FN_ADDR_OUT: return 1'b1;
      FN_ADDR_IN:  return 1'b0;
      default:     return dir | oet;
    endcase
  endfunction
endpackage

// File: rtl/port_regs.sv
module port_regs
  import mcu_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        reg_sel,
  input  logic [PORT_W-1:0] wr_data,
  input  logic [PORT_W-1:0] pin_in,
  output logic [PORT_W-1:0] dout_q,
  output logic [PORT_W-1:0] dir_q,
  output logic [PORT_W-1:0] cfg_q,
  output logic [PORT_W-1:0] rd_data
);
  reg_sel_e sel;
  logic wr_dout, wr_dir, wr_cfg;

  assign sel     = reg_sel_e'(reg_sel);
  assign wr_dout = wr_en && (sel == SEL_DOUT);
  assign wr_dir  = wr_en && (sel == SEL_DIR);
  assign wr_cfg  = wr_en && (sel == SEL_CFG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout_q <= '0;
      dir_q  <= '0;
      cfg_q  <= '0;
    end else begin
      if (wr_dout) dout_q <= wr_data;
      if (wr_dir)  dir_q  <= wr_data;
      if (wr_cfg)  cfg_q  <= wr_data & CFG_WMASK;
    end
  end

  always_comb begin
    case (sel)
      SEL_PINS: rd_data = pin_in;
      SEL_DOUT: rd_data = dout_q;
      SEL_DIR:  rd_data = dir_q;
      default:  rd_data = cfg_q;
    endcase
  end

  // R3
  dout_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == 2'd1) |=> dout_q == $past(wr_data));

  // R4
  cfg_rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[RSV_BIT] == 1'b0);

  // R10
  pins_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == 2'd0) |=> ($stable(dout_q) && $stable(dir_q) && $stable(cfg_q)));
endmodule

// File: rtl/port_addr_latch.sv
module port_addr_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ale,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] held_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   held_q <= '0;
    else if (ale) held_q <= d;
  end

  // transparent while ale is high, holding once it falls
  assign q = ale ? d : held_q;

  // R7 R8
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ale ##1 !ale) |-> q == $past(q));
endmodule

// File: rtl/port_pin_drive.sv
module port_pin_drive
  import mcu_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  port_fn_e          fn,
  input  logic [PORT_W-1:0] dout,
  input  logic [PORT_W-1:0] lgc,
  input  logic [PORT_W-1:0] adr,
  input  logic [PORT_W-1:0] dir,
  input  logic [PORT_W-1:0] oet,
  input  logic [PORT_W-1:0] od_en,
  output logic [PORT_W-1:0] pin_out,
  output logic [PORT_W-1:0] pin_oe
);
  logic [PORT_W-1:0] src_v, drv_req;

  for (genvar i = 0; i < PORT_W; i++) begin : g_pin
    assign src_v[i]   = src_bit(fn, dout[i], lgc[i], adr[i]);
    assign drv_req[i] = drive_bit(fn, dir[i], oet[i]);
    if (i >= OD_LSB) begin : g_od
      assign pin_out[i] = od_en[i] ? 1'b0 : src_v[i];
      assign pin_oe[i]  = drv_req[i] & (~od_en[i] | ~src_v[i]);
      // R9
      od_never_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (od_en[i] && pin_oe[i]) |-> !pin_out[i]);
    end else begin : g_pp
      assign pin_out[i] = src_v[i];
      assign pin_oe[i]  = drv_req[i];
      // R5
      lower_push_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fn == FN_GPIO) |-> pin_oe[i] == (dir[i] | oet[i]));
    end
  end

  // R8
  addr_in_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fn == FN_ADDR_IN) |-> pin_oe == '0);
endmodule

// File: rtl/mcu_port.sv
module mcu_port
  import mcu_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] reg_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       ale,
  input  logic [7:0] addr_bus,
  input  logic [7:0] oe_term,
  input  logic [7:0] logic_out,
  input  logic [7:0] pin_in,
  output logic [7:0] pin_out,
  output logic [7:0] pin_oe,
  output logic [7:0] addr_hi
);
  logic [PORT_W-1:0] dout_q, dir_q, cfg_q, od_en, adr_lat, pin_lat;
  port_fn_e fn;
  logic     cap_en;

  assign fn     = port_fn_e'(cfg_q[1:0]);
  assign cap_en = cfg_q[CAP_BIT];
  assign od_en  = {cfg_q[PORT_W-1:OD_LSB], {OD_LSB{1'b0}}};

  port_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel),
    .wr_data(wr_data), .pin_in(pin_in),
    .dout_q(dout_q), .dir_q(dir_q), .cfg_q(cfg_q), .rd_data(rd_data)
  );

  port_addr_latch #(.W(PORT_W)) u_bus_lat (
    .clk(clk), .rst_n(rst_n), .ale(ale), .d(addr_bus), .q(adr_lat)
  );

  port_addr_latch #(.W(PORT_W)) u_pin_lat (
    .clk(clk), .rst_n(rst_n), .ale(ale), .d(pin_in), .q(pin_lat)
  );

  port_pin_drive u_drive (
    .clk(clk), .rst_n(rst_n), .fn(fn), .dout(dout_q), .lgc(logic_out),
    .adr(adr_lat), .dir(dir_q), .oet(oe_term), .od_en(od_en),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  always_comb begin
    if (fn != FN_ADDR_IN) addr_hi = '0;
    else if (cap_en)      addr_hi = pin_lat;
    else                  addr_hi = pin_in;
  end

  // R8
  addr_hi_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fn != FN_ADDR_IN) |-> addr_hi == '0);
endmodule

// File: tb/mcu_port_tb.sv
module mcu_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [7:0] wr_data = '0, addr_bus = '0, oe_term = '0, logic_out = '0, pin_in = '0;
  logic       ale = 1'b0;
  logic [7:0] rd_data, pin_out, pin_oe, addr_hi;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  mcu_port u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel), .wr_data(wr_data),
    .rd_data(rd_data), .ale(ale), .addr_bus(addr_bus), .oe_term(oe_term),
    .logic_out(logic_out), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .addr_hi(addr_hi)
  );

  // cfg, dir, dout, oe_term, logic_out, expected pin_out, expected pin_oe
  localparam int NV = 6;
  localparam logic [55:0] VEC [NV] = '{
    {8'h00, 8'hF0, 8'hA5, 8'h03, 8'h00, 8'hA5, 8'hF3},  // R5
    {8'h00, 8'h00, 8'h3C, 8'h00, 8'h00, 8'h3C, 8'h00},  // R5
    {8'h01, 8'hFF, 8'h00, 8'h00, 8'h96, 8'h96, 8'hFF},  // R6
    {8'h01, 8'h0F, 8'hFF, 8'h10, 8'h5A, 8'h5A, 8'h1F},  // R6
    {8'hF0, 8'hFF, 8'hA5, 8'h00, 8'h00, 8'h05, 8'h5F},  // R9
    {8'h51, 8'h00, 8'h00, 8'hF0, 8'hFF, 8'hAF, 8'hA0}   // R9
  };

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; reg_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [1:0] sel, logic [7:0] exp);
    reg_sel = sel;
    #1;
    check(req, rd_data, exp);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: got 00 expected 01");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd_chk("R1 dout", 2'd1, 8'h00);
    rd_chk("R1 dir", 2'd2, 8'h00);
    rd_chk("R1 cfg", 2'd3, 8'h00);
    #1 check("R1 oe", pin_oe, 8'h00);

    // table walk over drive functions
    for (int k = 0; k < NV; k++) begin
      wr(2'd3, VEC[k][55:48]);
      wr(2'd2, VEC[k][47:40]);
      wr(2'd1, VEC[k][39:32]);
      oe_term = VEC[k][31:24];
      logic_out = VEC[k][23:16];
      #1;
      check("R5/R6/R9 out", pin_out, VEC[k][15:8]);
      check("R5/R6/R9 oe", pin_oe, VEC[k][7:0]);
    end
    oe_term = '0; logic_out = '0;

    // R2 live pins and R3 readback independent of pins
    wr(2'd3, 8'h00);
    wr(2'd1, 8'hC3);
    pin_in = 8'h5A;
    rd_chk("R2 pins", 2'd0, 8'h5A);
    pin_in = 8'h81;
    rd_chk("R2 pins follow", 2'd0, 8'h81);
    rd_chk("R3 dout readback", 2'd1, 8'hC3);

    // R4 register readback, reserved bit
    wr(2'd2, 8'h69);
    rd_chk("R4 dir", 2'd2, 8'h69);
    wr(2'd3, 8'h0F);
    rd_chk("R4 cfg rsv", 2'd3, 8'h07);

    // R10 write to pins location ignored
    wr(2'd0, 8'hFF);
    rd_chk("R10 dout", 2'd1, 8'hC3);
    rd_chk("R10 dir", 2'd2, 8'h69);
    rd_chk("R10 cfg", 2'd3, 8'h07);

    // R7 address output through transparent latch
    wr(2'd3, 8'h02);
    ale = 1'b1; addr_bus = 8'h3E;
    #1 check("R7 transparent", pin_out, 8'h3E);
    check("R7 all driven", pin_oe, 8'hFF);
    @(negedge clk);
    ale = 1'b0; addr_bus = 8'hC1;
    #1 check("R7 hold", pin_out, 8'h3E);
    @(negedge clk);
    #1 check("R7 hold later", pin_out, 8'h3E);
    check("R8 idle addr_hi", addr_hi, 8'h00);

    // R8 address input, live then captured
    wr(2'd3, 8'h03);
    pin_in = 8'h42;
    #1 check("R8 live", addr_hi, 8'h42);
    check("R8 no drive", pin_oe, 8'h00);
    wr(2'd3, 8'h07);
    ale = 1'b1; pin_in = 8'h81;
    #1 check("R8 cap transparent", addr_hi, 8'h81);
    @(negedge clk);
    ale = 1'b0; pin_in = 8'h18;
    #1 check("R8 cap hold", addr_hi, 8'h81);

    // R1 reset returns to defaults
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rd_chk("R1 cfg after reset", 2'd3, 8'h00);
    check("R1 addr_hi after reset", addr_hi, 8'h00);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule